// File: doc/BRIEF.md
# Supervisory Reset Generator with Manual Reset

This block produces the system reset for a chip from two digital causes. The first is an under-voltage flag (`uv_flag`, active high) that an external comparator has already produced and synchronized. The second is an asynchronous active-low manual-reset request (`mr_n`), which may come from a pushbutton or from a wired-OR of logic sources. The block drives complementary reset outputs and a reset-active level that neighbouring supervisory logic uses to clear its state. It also drives a one-cycle strobe that marks each new entry into reset from normal operation.

The manual request passes through a two-flop synchronizer and then a minimum-width filter, so a glitch shorter than the qualification time is ignored. Once every cause is gone, one shared hold-off timer keeps reset asserted for a fixed time. If any cause returns while the timer runs, the timer starts again from zero when that cause next clears. All times are clock cycles derived from a tick-rate parameter (`TICKS_PER_US`): the manual qualification window is `MR_CYC = TICKS_PER_US*MR_MIN_US` and the hold-off is `HOLD_CYC = TICKS_PER_US*HOLD_US`.

The controller has three states. ST_ASSERT: a cause is present or power-on reset has just ended. ST_HOLD: no cause is present and the hold-off counter is running. ST_RUN: reset is released. It has four transitions:
- power-on reset puts it in ST_ASSERT;
- ST_ASSERT goes to ST_HOLD when no cause is seen, and the counter is cleared;
- ST_HOLD goes back to ST_ASSERT on any cause, and goes to ST_RUN when the counter reaches `HOLD_CYC-1`;
- ST_RUN goes to ST_ASSERT on any cause, and this transition raises the strobe.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `sys_rst_n` is 0, `sys_rst` is 1, `rst_active` is 1 and `rst_strobe` is 0.
- R2: `uv_flag` high when sampled at a clock edge makes `sys_rst` 1 right after that edge, and reset stays asserted for as long as the flag stays high.
- R3: Each edge shifts `mr_n` into a two-flop synchronizer. Once the synchronized value has been sampled low on `MR_CYC` consecutive edges, reset asserts after the `MR_CYC`-th such edge. It remains asserted while `mr_n` stays low.
- R4: If `mr_n` is low for fewer than `MR_CYC` consecutive sampled cycles, `sys_rst_n`, `rst_active` and `rst_strobe` do not change.
- R5: Suppose the first edge at which no cause is seen is edge E. Then `sys_rst_n` rises right after edge E+`HOLD_CYC`, so reset lasts `HOLD_CYC`+1 cycles counted from E.
- R6: A cause that appears during the hold-off returns the block to the asserted state. The full hold-off then starts again from the first edge at which no cause is seen.
- R7: `sys_rst` is always the complement of `sys_rst_n`, and `rst_active` always equals `sys_rst`.
- R8: `rst_strobe` is 1 for exactly one cycle, at the same edge where reset re-asserts from the released state. It is never 1 during power-up or during hold-off re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| uv_flag | input | 1 | Synchronized under-voltage flag, active high |
| mr_n | input | 1 | Asynchronous manual reset request, active low |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |
| rst_active | output | 1 | Reset-active level for clearing other blocks |
| rst_strobe | output | 1 | One-cycle pulse on each new reset entry from run |

## Verification
The hardest situation to reach from the ports is a cause that returns during the hold-off. It has to arrive after the countdown has started and before the countdown ends, and a manual request only counts after the synchronizer and filter delays. The stimulus includes a directed case with a one-cycle under-voltage pulse in the middle of the hold-off. It also mixes random manual pulses whose widths fall on both sides of `MR_CYC` with random gaps shorter than the hold-off. A cycle-level model in the bench predicts every output on every cycle.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
    typedef enum logic [1:0] {
        ST_ASSERT = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RUN    = 2'd2
    } rst_state_e;
endpackage

// File: rtl/mrr_sync.sv
module mrr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pipe_q[g] <= RST_VAL;
                else if (g == 0)
                    pipe_q[g] <= d_i;
                else
                    pipe_q[g] <= pipe_q[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mrr_filter.sv
module mrr_filter #(
    parameter int MIN_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_s_n,
    output logic req_o
);
    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] low_cnt_q;
    logic          req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            req_q     <= 1'b0;
        end else if (mr_s_n) begin
            low_cnt_q <= '0;
            req_q     <= 1'b0;
        end else if (low_cnt_q == CW'(MIN_CYC - 1)) begin
            req_q     <= 1'b1;
        end else begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign req_o = req_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !mr_s_n) |=> req_q);

    // R4
    req_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(low_cnt_q) == CW'(MIN_CYC - 1));
endmodule

// File: rtl/rst_fsm.sv
module rst_fsm
    import sup_rst_pkg::*;
#(
    parameter int HOLD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic strobe_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    rst_state_e    state_q, state_d;
    logic [HW-1:0] cnt_q, cnt_d;
    logic          rst_n_q, rst_q, strobe_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ASSERT: begin
                if (!cause_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end
            end
            ST_HOLD: begin
                if (cause_i)
                    state_d = ST_ASSERT;
                else if (cnt_q == HW'(HOLD_CYC - 1))
                    state_d = ST_RUN;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            ST_RUN: begin
                if (cause_i)
                    state_d = ST_ASSERT;
            end
            default: state_d = ST_ASSERT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ASSERT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_n_q  <= 1'b0;
            rst_q    <= 1'b1;
            strobe_q <= 1'b0;
        end else begin
            rst_n_q  <= (state_d == ST_RUN);
            rst_q    <= (state_d != ST_RUN);
            strobe_q <= (state_q == ST_RUN) && cause_i;
        end
    end

    assign rst_n_o  = rst_n_q;
    assign rst_o    = rst_q;
    assign strobe_o = strobe_q;

    // R2
    cause_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> rst_q);

    // R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_q) |-> ($past(state_q) == ST_HOLD && $past(cnt_q) == HW'(HOLD_CYC - 1)));

    // R6
    retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cause_i) |=> state_q == ST_ASSERT);

    // R7
    inv_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q != rst_n_q);

    // R8
    strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int TICKS_PER_US = 100,
    parameter int MR_MIN_US    = 25,
    parameter int HOLD_US      = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag,
    input  logic mr_n,
    output logic sys_rst_n,
    output logic sys_rst,
    output logic rst_active,
    output logic rst_strobe
);
    localparam int MR_CYC   = TICKS_PER_US * MR_MIN_US;
    localparam int HOLD_CYC = TICKS_PER_US * HOLD_US;

    logic mr_s_n;
    logic mr_req;
    logic cause;
    logic rst_hi;

    mrr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mr_n),
        .q_o   (mr_s_n)
    );

    mrr_filter #(.MIN_CYC(MR_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .mr_s_n (mr_s_n),
        .req_o  (mr_req)
    );

    assign cause = uv_flag | mr_req;

    rst_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_i  (cause),
        .rst_n_o  (sys_rst_n),
        .rst_o    (rst_hi),
        .strobe_o (rst_strobe)
    );

    assign sys_rst    = rst_hi;
    assign rst_active = rst_hi;

    // R1
    por_chk: assert property (@(posedge clk) !rst_n |=> (!sys_rst_n && !rst_strobe));
endmodule

// File: tb/sup_reset_gen_tb.sv
module sup_reset_gen_tb_top;
    localparam int TPU = 1;
    localparam int MRU = 5;
    localparam int HLU = 200;
    localparam int MR_CYC   = TPU * MRU;
    localparam int HOLD_CYC = TPU * HLU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_flag = 1'b0;
    logic mr_n = 1'b1;
    logic sys_rst_n, sys_rst, rst_active, rst_strobe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit live = 1'b0;
    bit strobe_seen = 1'b0;
    string phase = "R1";

    always #2 clk = ~clk;

    sup_reset_gen #(.TICKS_PER_US(TPU), .MR_MIN_US(MRU), .HOLD_US(HLU)) dut_i (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .mr_n(mr_n),
        .sys_rst_n(sys_rst_n), .sys_rst(sys_rst),
        .rst_active(rst_active), .rst_strobe(rst_strobe)
    );

    // reference model state
    logic m_s1, m_s2, m_req, m_rst, m_strobe;
    int   m_low, m_quiet;

    function automatic int next_quiet(input logic cause, input int q);
        if (cause) return 0;
        return (q <= HOLD_CYC) ? q + 1 : q;
    endfunction

    function automatic int next_low(input logic s2, input int l);
        if (s2) return 0;
        return (l < MR_CYC) ? l + 1 : l;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_req = 1'b0;
            m_rst = 1'b1; m_strobe = 1'b0; m_low = 0; m_quiet = 0;
        end else begin
            logic cause;
            cause    = uv_flag | m_req;
            m_strobe = !m_rst && cause;
            m_quiet  = next_quiet(cause, m_quiet);
            m_rst    = (m_quiet < HOLD_CYC + 1);
            m_low    = next_low(m_s2, m_low);
            m_req    = (m_low >= MR_CYC);
            m_s2     = m_s1;
            m_s1     = mr_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (live) begin
            if (rst_strobe) strobe_seen = 1'b1;
            check(sys_rst_n == !m_rst, phase, sys_rst_n, !m_rst);
            check(rst_strobe == m_strobe, "R8 strobe", rst_strobe, m_strobe);
            check(sys_rst == !sys_rst_n && rst_active == sys_rst, "R7 inverse",
                  {sys_rst, rst_active}, {!sys_rst_n, !sys_rst_n});
        end
    end

    task automatic run(input int n, input logic uv, input logic mr);
        uv_flag = uv;
        mr_n    = mr;
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int rel;
        void'($urandom(32'd4242));
        live = 1'b1;
        phase = "R1";
        repeat (4) @(negedge clk);
        check(sys_rst_n == 1'b0 && rst_strobe == 1'b0, "R1 in reset", sys_rst_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sys_rst == 1'b1 && rst_active == 1'b1, "R1 after clear", sys_rst, 1);

        phase = "R5";
        rel = 0;
        while (!sys_rst_n && rel < 400) begin @(negedge clk); rel++; end
        check(rel == HOLD_CYC, "R5 release time", rel, HOLD_CYC);
        check(!strobe_seen, "R8 no strobe at power-up", strobe_seen, 0);

        phase = "R4";
        strobe_seen = 1'b0;
        run(MR_CYC - 1, 1'b0, 1'b0);
        run(20, 1'b0, 1'b1);
        check(sys_rst_n == 1'b1 && !strobe_seen, "R4 short pulse ignored", sys_rst_n, 1);

        phase = "R3";
        run(30, 1'b0, 1'b0);
        check(sys_rst_n == 1'b0, "R3 manual held", sys_rst_n, 0);
        check(strobe_seen, "R8 strobe on manual", strobe_seen, 1);
        phase = "R5";
        run(HOLD_CYC + 10, 1'b0, 1'b1);
        check(sys_rst_n == 1'b1, "R5 release after manual", sys_rst_n, 1);

        phase = "R2";
        run(3, 1'b1, 1'b1);
        check(sys_rst_n == 1'b0, "R2 under-voltage", sys_rst_n, 0);
        run(HOLD_CYC + 5, 1'b0, 1'b1);

        phase = "R6";
        run(1, 1'b1, 1'b1);
        run(100, 1'b0, 1'b1);
        strobe_seen = 1'b0;
        run(1, 1'b1, 1'b1);
        run(HOLD_CYC - 20, 1'b0, 1'b1);
        check(sys_rst_n == 1'b0 && !strobe_seen, "R6 restart from zero", sys_rst_n, 0);
        run(30, 1'b0, 1'b1);
        check(sys_rst_n == 1'b1, "R6 final release", sys_rst_n, 1);

        phase = "R3 random";
        for (int i = 0; i < 40; i++) begin
            int k;
            k = $urandom_range(0, 2);
            if (k == 0)      run($urandom_range(1, 30), 1'b1, 1'b1);
            else if (k == 1) run($urandom_range(1, 2 * MR_CYC), 1'b0, 1'b0);
            else             run($urandom_range(1, HOLD_CYC + 30), 1'b0, 1'b1);
        end
        run(HOLD_CYC + 5, 1'b0, 1'b1);
        check(sys_rst_n == 1'b1, "R5 quiet end", sys_rst_n, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule